// File: doc/BRIEF.md
# Predicated Bit-Register Logic Unit

This block keeps two 16-bit bit registers and executes one 21-bit bit-manipulation instruction per clock. Each instruction picks one of the two registers and one 4-bit segment of it. Every other operand is a bit position inside that segment: a predicate bit, two source bits and two destination bits. An 8-bit field encodes an arbitrary two-input, two-output boolean gate as a pair of 4-entry truth tables.

When the instruction is valid and its predicate bit is set, both gate outputs are written back into the segment at the next clock edge. When the predicate bit is clear, nothing changes. Each register also has a parallel load port, so software-visible state can be seeded or overwritten directly. A load wins over an instruction that targets the same register in the same cycle. Both registers are always visible on a flat read-back output.

Top module: `pbl_unit`

## Requirements
- R1: While rst_n is low, both registers are cleared to zero, and a load request is ignored.
- R2: instr[20] selects the register (0 = breg_q[15:0], 1 = breg_q[31:16]). instr[19:18] = k selects the segment holding register bits 4k+3..4k. An instruction never changes a bit outside that segment.
- R3: instr[17:16] selects the predicate bit within the segment. When that bit is 0, the instruction leaves both registers unchanged.
- R4: instr[15:14] picks source bit a and instr[13:12] picks source bit b within the segment. With f = instr[11:4] and i = {a,b}, output A is f[4+i] and output B is f[i].
- R5: instr[3:2] selects the destination bit of output A and instr[1:0] selects the destination bit of output B. Both are written at the clock edge that samples the valid, predicated instruction, so at most two bits change.
- R6: When both destination selectors name the same bit, output A is stored there and output B is discarded.
- R7: Sources take the register value from before the edge, so a destination that is also a source still uses the old bit.
- R8: When load_en[r] is high, register r takes load_data[16r+15:16r] and any instruction write to it in that cycle is dropped. An instruction that targets the other register still takes effect.
- R9: When instr_valid is low and no load is requested, both registers hold their value.
- R10: A load with no instruction updates the register at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 21 | Instruction word |
| load_en | input | 2 | Per-register parallel load request |
| load_data | input | 32 | Load values, register r in bits 16r+15..16r |
| breg_q | output | 32 | Both register contents, register r in bits 16r+15..16r |

## Verification
The bench targets the following cases:
- Aliased destinations. A design that lets output B win would store the wrong bit.
- A destination that is also a source. A design that reads after writing would feed the new bit back into the gate.
- A load colliding with an instruction on the same register. A design with the wrong priority would mix the loaded word with a written segment. A design that blocks the whole unit on a load would also lose the write to the other register.
- A clear predicate bit, every segment of both registers, and a sweep of gate functions. These catch a swapped truth-table half, a misplaced segment, or a predicate taken from the wrong bit.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

  localparam int PBL_REG_W    = 16;
  localparam int PBL_SEG_W    = 4;
  localparam int PBL_NUM_REGS = 2;
  localparam int PBL_TT_SIZE  = 4;                // entries per truth table
  localparam int PBL_FUNC_W   = 2 * PBL_TT_SIZE;  // two outputs

  // Evaluate the two-output gate: upper half drives output A, lower half B.
  function automatic logic [1:0] gate_eval(input logic [PBL_FUNC_W-1:0] fn,
                                           input logic a, input logic b);
    logic [1:0] idx;
    logic [1:0] res;
    idx    = {a, b};
    res[1] = fn[PBL_TT_SIZE + int'(idx)];
    res[0] = fn[int'(idx)];
    return res;
  endfunction

endpackage

// File: rtl/pbl_decode.sv
module pbl_decode #(
  parameter int REG_SEL_W = 1,
  parameter int SEG_SEL_W = 2,
  parameter int BIT_SEL_W = 2,
  parameter int FUNC_W    = 8,
  localparam int INSTR_W  = REG_SEL_W + SEG_SEL_W + 5 * BIT_SEL_W + FUNC_W
) (
  input  logic [INSTR_W-1:0]   instr,
  output logic [REG_SEL_W-1:0] reg_sel,
  output logic [SEG_SEL_W-1:0] seg_sel,
  output logic [BIT_SEL_W-1:0] pred_sel,
  output logic [BIT_SEL_W-1:0] src_a,
  output logic [BIT_SEL_W-1:0] src_b,
  output logic [FUNC_W-1:0]    func,
  output logic [BIT_SEL_W-1:0] dst_a,
  output logic [BIT_SEL_W-1:0] dst_b
);
  // Field layout, most significant first: reg, seg, pred, srcA, srcB, func, dstA, dstB
  localparam int DB_LO  = 0;
  localparam int DA_LO  = DB_LO + BIT_SEL_W;
  localparam int FN_LO  = DA_LO + BIT_SEL_W;
  localparam int SB_LO  = FN_LO + FUNC_W;
  localparam int SA_LO  = SB_LO + BIT_SEL_W;
  localparam int PR_LO  = SA_LO + BIT_SEL_W;
  localparam int SG_LO  = PR_LO + BIT_SEL_W;
  localparam int RS_LO  = SG_LO + SEG_SEL_W;

  assign dst_b    = instr[DB_LO +: BIT_SEL_W];
  assign dst_a    = instr[DA_LO +: BIT_SEL_W];
  assign func     = instr[FN_LO +: FUNC_W];
  assign src_b    = instr[SB_LO +: BIT_SEL_W];
  assign src_a    = instr[SA_LO +: BIT_SEL_W];
  assign pred_sel = instr[PR_LO +: BIT_SEL_W];
  assign seg_sel  = instr[SG_LO +: SEG_SEL_W];
  assign reg_sel  = instr[RS_LO +: REG_SEL_W];
endmodule

// File: rtl/pbl_seg_exec.sv
module pbl_seg_exec
  import pbl_pkg::*;
#(
  parameter int SEG_W     = 4,
  localparam int BIT_SEL_W = $clog2(SEG_W)
) (
  input  logic [SEG_W-1:0]      seg_old,
  input  logic [BIT_SEL_W-1:0]  pred_sel,
  input  logic [BIT_SEL_W-1:0]  src_a,
  input  logic [BIT_SEL_W-1:0]  src_b,
  input  logic [PBL_FUNC_W-1:0] func,
  input  logic [BIT_SEL_W-1:0]  dst_a,
  input  logic [BIT_SEL_W-1:0]  dst_b,
  output logic                  pred_ok,
  output logic [SEG_W-1:0]      seg_new
);
  logic [1:0] gate_out;

  assign pred_ok  = seg_old[pred_sel];
  // Sources come from the pre-edge segment value.
  assign gate_out = gate_eval(func, seg_old[src_a], seg_old[src_b]);

  always_comb begin
    seg_new        = seg_old;
    seg_new[dst_b] = gate_out[0];
    seg_new[dst_a] = gate_out[1];   // later assignment: A wins on alias
  end
endmodule

// File: rtl/pbl_breg.sv
module pbl_breg #(
  parameter int REG_W = 16,
  parameter int SEG_W = 4,
  localparam int SEG_SEL_W = $clog2(REG_W / SEG_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [REG_W-1:0]     load_data,
  input  logic                 wr_en,
  input  logic [SEG_SEL_W-1:0] wr_seg,
  input  logic [SEG_W-1:0]     wr_val,
  output logic [REG_W-1:0]     q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load_en) begin
      q <= load_data;
    end else if (wr_en) begin
      q[int'(wr_seg) * SEG_W +: SEG_W] <= wr_val;
    end
  end
endmodule

// File: rtl/pbl_unit.sv
module pbl_unit
  import pbl_pkg::*;
#(
  parameter int REG_W    = PBL_REG_W,
  parameter int SEG_W    = PBL_SEG_W,
  parameter int NUM_REGS = PBL_NUM_REGS,
  localparam int NUM_SEGS  = REG_W / SEG_W,
  localparam int REG_SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int SEG_SEL_W = $clog2(NUM_SEGS),
  localparam int BIT_SEL_W = $clog2(SEG_W),
  localparam int INSTR_W   = REG_SEL_W + SEG_SEL_W + 5 * BIT_SEL_W + PBL_FUNC_W,
  localparam int FLAT_W    = NUM_REGS * REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [NUM_REGS-1:0] load_en,
  input  logic [FLAT_W-1:0]  load_data,
  output logic [FLAT_W-1:0]  breg_q
);
  logic [REG_SEL_W-1:0]  reg_sel;
  logic [SEG_SEL_W-1:0]  seg_sel;
  logic [BIT_SEL_W-1:0]  pred_sel, src_a, src_b, dst_a, dst_b;
  logic [PBL_FUNC_W-1:0] func;

  logic [REG_W-1:0]      regs [NUM_REGS];
  logic [REG_W-1:0]      reg_cur;
  logic [SEG_W-1:0]      seg_old, seg_new;
  logic                  reg_sel_ok;
  logic                  pred_ok;
  logic                  instr_fire;   // event: predicated write takes place
  logic [NUM_REGS-1:0]   wr_hit;
  logic [FLAT_W-1:0]     seg_mask;     // event: bits the instruction may touch

  pbl_decode #(
    .REG_SEL_W(REG_SEL_W), .SEG_SEL_W(SEG_SEL_W),
    .BIT_SEL_W(BIT_SEL_W), .FUNC_W(PBL_FUNC_W)
  ) i_decode (
    .instr(instr), .reg_sel(reg_sel), .seg_sel(seg_sel), .pred_sel(pred_sel),
    .src_a(src_a), .src_b(src_b), .func(func), .dst_a(dst_a), .dst_b(dst_b)
  );

  assign reg_sel_ok = (int'(reg_sel) < NUM_REGS);

  always_comb begin
    reg_cur = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (int'(reg_sel) == r) reg_cur = regs[r];
    end
  end

  assign seg_old = reg_cur[int'(seg_sel) * SEG_W +: SEG_W];

  pbl_seg_exec #(.SEG_W(SEG_W)) i_exec (
    .seg_old(seg_old), .pred_sel(pred_sel), .src_a(src_a), .src_b(src_b),
    .func(func), .dst_a(dst_a), .dst_b(dst_b),
    .pred_ok(pred_ok), .seg_new(seg_new)
  );

  assign instr_fire = instr_valid & reg_sel_ok & pred_ok;

  always_comb begin
    seg_mask = '0;
    if (instr_fire)
      seg_mask[int'(reg_sel) * REG_W + int'(seg_sel) * SEG_W +: SEG_W] = '1;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign wr_hit[r] = instr_fire && (int'(reg_sel) == r);

    pbl_breg #(.REG_W(REG_W), .SEG_W(SEG_W)) i_breg (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en[r]), .load_data(load_data[r*REG_W +: REG_W]),
      .wr_en(wr_hit[r]), .wr_seg(seg_sel), .wr_val(seg_new),
      .q(regs[r])
    );

    assign breg_q[r*REG_W +: REG_W] = regs[r];
  end
endmodule

// File: rtl/pbl_unit_chk.sv
module pbl_unit_chk #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 2,
  localparam int FLAT_W  = NUM_REGS * REG_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                instr_valid,
  input logic [NUM_REGS-1:0] load_en,
  input logic [FLAT_W-1:0]   load_data,
  input logic [FLAT_W-1:0]   breg_q,
  input logic                pred_ok,
  input logic                instr_fire,
  input logic [FLAT_W-1:0]   seg_mask
);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_valid && load_en == '0) |=> $stable(breg_q));

  assert_pred_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !pred_ok && load_en == '0) |=> $stable(breg_q));

  assert_two_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en == '0) |=> ($countones(breg_q ^ $past(breg_q)) <= 2));

  assert_seg_confined_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en == '0 && instr_fire) |=>
      (((breg_q ^ $past(breg_q)) & ~$past(seg_mask)) == '0));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ld
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_en[r] |=> (breg_q[r*REG_W +: REG_W] == $past(load_data[r*REG_W +: REG_W])));
  end
endmodule

bind pbl_unit pbl_unit_chk #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) i_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .load_en(load_en),
  .load_data(load_data), .breg_q(breg_q), .pred_ok(pred_ok),
  .instr_fire(instr_fire), .seg_mask(seg_mask)
);

// File: tb/test_pbl_unit.sv
module test_pbl_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [20:0] instr;
  logic [1:0]  load_en;
  logic [31:0] load_data;
  logic [31:0] breg_q;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  logic [15:0] mdl [2];

  always #10 clk = ~clk;   // 50 MHz

  pbl_unit i_pbl_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .load_en(load_en), .load_data(load_data), .breg_q(breg_q)
  );

  function automatic logic [20:0] mk(input logic r, input logic [1:0] sg,
    input logic [1:0] pr, input logic [1:0] sa, input logic [1:0] sb,
    input logic [7:0] fn, input logic [1:0] da, input logic [1:0] db);
    return {r, sg, pr, sa, sb, fn, da, db};
  endfunction

  // Truth-table lookup written as nested selects.
  function automatic logic tt(input logic [3:0] t, input logic a, input logic b);
    return a ? (b ? t[3] : t[2]) : (b ? t[1] : t[0]);
  endfunction

  // Driver: apply one cycle of stimulus and push the expected next state.
  task automatic step(input logic v, input logic [20:0] ins, input logic [1:0] le,
                      input logic [31:0] ld, input string tag);
    logic [15:0] nxt [2];
    logic [3:0]  seg;
    logic        oa, ob;
    int          r, base;
    @(negedge clk);
    instr_valid = v; instr = ins; load_en = le; load_data = ld;
    nxt[0] = mdl[0]; nxt[1] = mdl[1];
    r    = int'(ins[20]);
    base = 4 * int'(ins[19:18]);
    seg  = mdl[r][base +: 4];
    if (v && seg[ins[17:16]]) begin
      oa = tt(ins[11:8], seg[ins[15:14]], seg[ins[13:12]]);
      ob = tt(ins[7:4],  seg[ins[15:14]], seg[ins[13:12]]);
      if (ins[3:2] != ins[1:0]) nxt[r][base + int'(ins[1:0])] = ob;
      nxt[r][base + int'(ins[3:2])] = oa;
    end
    if (le[0]) nxt[0] = ld[15:0];
    if (le[1]) nxt[1] = ld[31:16];
    mdl[0] = nxt[0]; mdl[1] = nxt[1];
    sb_q.push_back('{exp: {nxt[1], nxt[0]}, tag: tag});
  endtask

  // Monitor: compare after every clock edge that has an expectation.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (breg_q !== it.exp) begin
          n_fails++;
          $display("FAIL %s: got %h expected %h", it.tag, breg_q, it.exp);
        end
      end
    end
  end

  initial begin
    #(100000 * 20);
    n_fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    load_en = 2'b11; load_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    n_checks++;
    if (breg_q !== 32'h0) begin
      n_fails++;
      $display("FAIL R1: got %h expected %h", breg_q, 32'h0);
    end
    mdl[0] = '0; mdl[1] = '0;
    rst_n = 1'b1; load_en = 2'b00;

    // R10: plain loads
    step(1'b0, '0, 2'b01, 32'h0000_A5C3, "R10 load reg0");
    step(1'b0, '0, 2'b10, 32'h0F0F_0000, "R10 load reg1");
    // R9: garbage instruction with valid low
    step(1'b0, 21'h1FFFFF, 2'b00, 32'h1234_5678, "R9 idle");
    // R3: segment 0 of reg0 is 4'b0011, predicate bit 2 is 0
    step(1'b1, mk(1'b0, 2'd0, 2'd2, 2'd0, 2'd1, 8'hFF, 2'd2, 2'd3), 2'b00, '0, "R3 pred clear");
    // R3/R4: predicate bit 0 set, AND into dst 3, XOR into dst 2
    step(1'b1, mk(1'b0, 2'd0, 2'd0, 2'd0, 2'd1, 8'h86, 2'd3, 2'd2), 2'b00, '0, "R4 and/xor");
    // R2: every segment of both registers
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, mk(r[0], s[1:0], 2'd0, 2'd1, 2'd2, 8'h5A, 2'd1, 2'd2), 2'b00, '0, "R2 segment sweep");
        step(1'b1, mk(r[0], s[1:0], 2'd1, 2'd3, 2'd0, 8'hE1, 2'd0, 2'd3), 2'b00, '0, "R2 segment sweep b");
      end
    end
    // R4: all source pairs under several gate functions, predicate forced by reload
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i < 4; i++) begin
        step(1'b0, '0, 2'b01, {16'h0, 12'h000, 2'b10, i[1:0]} | 32'h0000_0008, "R10 seed");
        step(1'b1, mk(1'b0, 2'd0, 2'd3, 2'd1, 2'd0, 8'h1D + 8'(f * 37), 2'd2, 2'd3),
             2'b00, '0, "R4 truth table");
      end
    end
    // R6: aliased destinations, A forced to 1 and B to 0
    step(1'b0, '0, 2'b10, 32'h0001_0000, "R10 seed r1");
    step(1'b1, mk(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hF0, 2'd2, 2'd2), 2'b00, '0, "R6 alias A wins");
    step(1'b1, mk(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'h0F, 2'd2, 2'd2), 2'b00, '0, "R6 alias A wins clear");
    // R7: in-place invert of bit 1, copy old bit 1 to bit 3
    step(1'b0, '0, 2'b01, 32'h0000_0003, "R10 seed r0");
    step(1'b1, mk(1'b0, 2'd0, 2'd0, 2'd1, 2'd1, 8'h3C, 2'd1, 2'd3), 2'b00, '0, "R7 read before write");
    // R8: load collides with instruction on same reg, then on other reg
    step(1'b1, mk(1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 2'd1, 2'd2), 2'b01, 32'h0000_7771, "R8 load wins same reg");
    step(1'b0, '0, 2'b10, 32'hFFFF_0000, "R10 seed r1 ones");
    step(1'b1, mk(1'b1, 2'd3, 2'd0, 2'd0, 2'd0, 8'h00, 2'd0, 2'd1), 2'b01, 32'h0000_4242, "R8 other reg still written");
    // Mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[31] | rv[30], rv[20:0], (rv[29:27] == 3'b000) ? rv[26:25] : 2'b00,
           $urandom, "R5 mixed traffic");
    end
    step(1'b0, '0, 2'b00, '0, "R9 drain");
    step(1'b0, '0, 2'b00, '0, "R9 drain");
    @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule